// File: doc/BRIEF.md
# Streaming Row Reduction Scheduler

This block adds up rows of numbers that arrive as one continuous stream. Each cycle at most one value comes in, tagged with the identifier of the row it belongs to and a flag that marks the final element of that row. A single adder pipeline of fixed depth is shared by every row in flight. Each cycle a controller decides which two operands enter that adder.

The controller chooses between three sources: the value leaving the adder, a partial sum parked in a per-tag buffer, and the two oldest entries of an arrival-ordered input queue. It applies a fixed order of preference. Integer addition modulo 2^DATA_W takes the place of a floating-point adder.

A row is finished when its last element has been taken in and only one value is left for it anywhere in the block. Finished sums are parked and released one per cycle, in the order in which the rows first appeared. The tag supplier reuses a tag only after the sum for that tag has been released.

Top module: `rowred_top`

## Requirements
- R1: When `in_vld` is high at a rising clock edge, the block accepts one value together with its tag and last-element flag into an input queue that preserves arrival order. At most one value is accepted per cycle.
- R2: The adder takes at most one operand pair per cycle and delivers the sum modulo 2^DATA_W exactly STAGES cycles later. For a fresh two-element row whose values are accepted at edges 1 and 2, `out_vld` is low after edge STAGES+3 and high after edge STAGES+4.
- R3: When the adder output has a valid value and the partial buffer holds a non-final entry with the same tag, that entry and the adder output are summed before any other choice is made.
- R4: Otherwise, when the input-queue head has the tag of the adder output, the head and the adder output are summed, and one queue entry is removed.
- R5: Otherwise, when the queue holds two or more values and the two oldest share a tag, those two are summed, and two queue entries are removed.
- R6: Otherwise, when the queue holds two or more values with different tags, the head is sent to the adder with 0 as its partner, and one queue entry is removed.
- R7: When none of the cases above applies, no operands enter the adder. In particular, a lone queued value that is not matched by the adder output stays in the queue and no sum appears for it.
- R8: An adder output that is not consumed by case R3 or R4 is written into the partial buffer at its tag. No buffer entry is ever overwritten.
- R9: An adder output is the final sum of its row when the row's last element has been accepted and no other value of that row remains in the queue, the pipeline or the buffer. The emitted sum equals the sum of all the row's values modulo 2^DATA_W.
- R10: Each finished row produces exactly one `out_vld` pulse carrying its sum and tag. Rows are emitted in the order of their first accepted element.
- R11: While `rst_n` is low, `out_vld` is low. After reset the input queue, the partial buffer, the pipeline and all row tracking are empty, so no value accepted before the reset affects any later sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | An input value is present this cycle |
| in_data | input | DATA_W | Value to be summed |
| in_tag | input | TAG_W | Row identifier of the value |
| in_last | input | 1 | Marks the final element of its row |
| out_vld | output | 1 | One-cycle pulse: a finished row sum is present |
| out_data | output | DATA_W | Finished row sum |
| out_tag | output | TAG_W | Tag of the finished row |

## Verification
The assertions rely on several assumptions about the inputs. The input queue is never offered a value while it is full and nothing leaves it. No tag is reused before its sum has been emitted. Every row ends with exactly one element flagged as last. The stimulus keeps to these rules as follows. A row gets a tag only when the bench has seen every earlier use of that tag emitted. The queue is deep compared with the pipeline, and the input stream contains idle cycles. The stream ends with single-element padding rows, which push the final lone value of each real row out of the queue.

// File: rtl/rowred_pkg.sv
package rowred_pkg;

  typedef enum logic [2:0] {
    RULE_NONE      = 3'd0,
    RULE_BUF_PIPE  = 3'd1,
    RULE_FIFO_PIPE = 3'd2,
    RULE_FIFO_PAIR = 3'd3,
    RULE_FIFO_ZERO = 3'd4
  } rule_e;

  // Fixed-priority operand selection; earlier tests win.
  function automatic rule_e pick_rule(input logic hit_buf,
                                      input logic pipe_matches_head,
                                      input logic have_one,
                                      input logic have_two,
                                      input logic head_pair_same);
    if (hit_buf)                           return RULE_BUF_PIPE;
    if (pipe_matches_head && have_one)     return RULE_FIFO_PIPE;
    if (have_two && head_pair_same)        return RULE_FIFO_PAIR;
    if (have_two)                          return RULE_FIFO_ZERO;
    return RULE_NONE;
  endfunction

endpackage

// File: rtl/rowred_fifo.sv
module rowred_fifo #(
  parameter int DW    = 16,
  parameter int TW    = 4,
  parameter int DEPTH = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [DW-1:0]                 push_data,
  input  logic [TW-1:0]                 push_tag,
  input  logic                          pop_one,
  input  logic                          pop_two,
  output logic [DW-1:0]                 head_data,
  output logic [TW-1:0]                 head_tag,
  output logic [DW-1:0]                 next_data,
  output logic [TW-1:0]                 next_tag,
  output logic [$clog2(DEPTH+1)-1:0]    level
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);
  localparam int EW = DW + TW;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [1:0]    n_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return s[AW-1:0];
  endfunction

  assign n_pop = pop_two ? 2'd2 : (pop_one ? 2'd1 : 2'd0);

  assign {head_tag, head_data} = mem[rd_ptr];
  assign {next_tag, next_data} = mem[step(rd_ptr, 1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= {push_tag, push_data};
        wr_ptr      <= step(wr_ptr, 1);
      end
      rd_ptr <= step(rd_ptr, int'(n_pop));
      level  <= level + LW'(push) - LW'(n_pop);
    end
  end

  // R1: a value is never offered to a full queue unless room is made
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && level == LW'(DEPTH)) |-> (n_pop != 2'd0));

  // R7: nothing is removed that is not there
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    LW'(n_pop) <= level);

endmodule

// File: rtl/rowred_pipe.sv
module rowred_pipe #(
  parameter int DW     = 16,
  parameter int TW     = 4,
  parameter int STAGES = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [TW-1:0] in_tag,
  output logic          out_vld,
  output logic [DW-1:0] out_sum,
  output logic [TW-1:0] out_tag
);

  logic          s_vld [STAGES];
  logic [DW-1:0] s_sum [STAGES];
  logic [TW-1:0] s_tag [STAGES];

  function automatic logic [DW-1:0] add_op(input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
    return a + b;
  endfunction

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) s_vld[0] <= 1'b0;
          else        s_vld[0] <= in_vld;
        end
        always_ff @(posedge clk) begin
          s_sum[0] <= add_op(in_a, in_b);
          s_tag[0] <= in_tag;
        end
        // R2: an issued pair enters the first stage
        p_issue_enters_r2: assert property (@(posedge clk) disable iff (!rst_n)
          in_vld |=> s_vld[0]);
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) s_vld[g] <= 1'b0;
          else        s_vld[g] <= s_vld[g-1];
        end
        always_ff @(posedge clk) begin
          s_sum[g] <= s_sum[g-1];
          s_tag[g] <= s_tag[g-1];
        end
        // R2: a valid value advances exactly one stage per cycle
        p_stage_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
          s_vld[g-1] |=> (s_vld[g] && s_sum[g] == $past(s_sum[g-1])));
      end
    end
  endgenerate

  assign out_vld = s_vld[STAGES-1];
  assign out_sum = s_sum[STAGES-1];
  assign out_tag = s_tag[STAGES-1];

endmodule

// File: rtl/rowred_store.sv
module rowred_store #(
  parameter int DW = 16,
  parameter int TW = 4,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_vld,
  input  logic [TW-1:0] acc_tag,
  input  logic          acc_last,
  input  logic          merge_vld,
  input  logic [TW-1:0] merge_tag,
  input  logic          pv,
  input  logic [TW-1:0] ptag,
  input  logic [DW-1:0] psum,
  input  logic          take_buf,
  input  logic          pipe_used,
  output logic          buf_hit,
  output logic [DW-1:0] buf_val,
  output logic          out_vld,
  output logic [DW-1:0] out_sum,
  output logic [TW-1:0] out_tag
);

  localparam int NT = 1 << TW;

  logic          b_vld [NT];
  logic          b_fin [NT];
  logic [DW-1:0] b_val [NT];
  logic [CW-1:0] cnt   [NT];
  logic          seen  [NT];
  logic          open  [NT];
  logic [TW-1:0] oq    [NT];
  logic [TW-1:0] oq_rd, oq_wr;
  logic [TW:0]   oq_n;

  logic          pipe_final;
  logic          store_pipe;
  logic          new_row;
  logic          emit;
  logic [TW-1:0] head;

  assign pipe_final = pv && (cnt[ptag] == CW'(1)) && seen[ptag];
  assign store_pipe = pv && !pipe_used;
  assign new_row    = acc_vld && !open[acc_tag];
  assign head       = oq[oq_rd];
  assign emit       = (oq_n != '0) && b_vld[head] && b_fin[head];
  assign buf_hit    = pv && b_vld[ptag] && !b_fin[ptag];
  assign buf_val    = b_val[ptag];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      oq_rd   <= '0;
      oq_wr   <= '0;
      oq_n    <= '0;
      for (int t = 0; t < NT; t++) begin
        b_vld[t] <= 1'b0;
        b_fin[t] <= 1'b0;
        cnt[t]   <= '0;
        seen[t]  <= 1'b0;
        open[t]  <= 1'b0;
      end
    end else begin
      out_vld <= emit;
      if (emit) begin
        out_sum <= b_val[head];
        out_tag <= head;
        oq_rd   <= oq_rd + 1'b1;
      end
      if (new_row) begin
        oq[oq_wr] <= acc_tag;
        oq_wr     <= oq_wr + 1'b1;
      end
      oq_n <= oq_n + (TW+1)'(new_row) - (TW+1)'(emit);

      for (int t = 0; t < NT; t++) begin
        // live-value count per row: +1 per accepted value, -1 per real merge
        if (store_pipe && pipe_final && ptag == TW'(t)) begin
          cnt[t]  <= '0;
          seen[t] <= 1'b0;
        end else begin
          cnt[t] <= cnt[t] + CW'(acc_vld && acc_tag == TW'(t))
                           - CW'(merge_vld && merge_tag == TW'(t));
          if (acc_vld && acc_last && acc_tag == TW'(t)) seen[t] <= 1'b1;
        end

        if (take_buf && ptag == TW'(t)) begin
          b_vld[t] <= 1'b0;
        end else if (store_pipe && ptag == TW'(t)) begin
          b_vld[t] <= 1'b1;
          b_fin[t] <= pipe_final;
          b_val[t] <= psum;
        end else if (emit && head == TW'(t)) begin
          b_vld[t] <= 1'b0;
          b_fin[t] <= 1'b0;
        end

        if (new_row && acc_tag == TW'(t))   open[t] <= 1'b1;
        else if (emit && head == TW'(t))    open[t] <= 1'b0;
      end
    end
  end

  // R8: a parked value never lands on an occupied slot
  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    store_pipe |-> !b_vld[ptag]);

  // R9: a final sum has no partner left in the buffer
  p_final_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_final |-> !b_vld[ptag]);

  // R10: the arrival-order queue never holds more rows than there are tags
  p_order_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    new_row |-> (oq_n < (TW+1)'(NT)) || emit);

  // R10: a released row leaves the order queue
  p_emit_pops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !new_row) |=> oq_n == $past(oq_n) - 1'b1);

endmodule

// File: rtl/rowred_top.sv
module rowred_top #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int FDEPTH = 32,
  parameter int STAGES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              in_last,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag
);
  import rowred_pkg::*;

  localparam int LW = $clog2(FDEPTH+1);
  localparam int CW = $clog2(FDEPTH + STAGES + 4) + 1;
  localparam logic [DATA_W-1:0] IDENT = '0;

  // queue side
  logic [DATA_W-1:0] head_data, next_data;
  logic [TAG_W-1:0]  head_tag, next_tag;
  logic [LW-1:0]     level;
  logic              pop_one, pop_two;
  // adder side
  logic              p_vld;
  logic [DATA_W-1:0] p_sum;
  logic [TAG_W-1:0]  p_tag;
  logic              iss_vld;
  logic [DATA_W-1:0] iss_a, iss_b;
  logic [TAG_W-1:0]  iss_tag;
  // buffer side
  logic              buf_hit;
  logic [DATA_W-1:0] buf_val;
  logic              take_buf, pipe_used, merge_vld;
  logic [TAG_W-1:0]  merge_tag;
  // decision
  rule_e             rule_now;
  logic              have_one, have_two, pipe_matches_head;

  assign have_one          = (level != '0);
  assign have_two          = (level >= LW'(2));
  assign pipe_matches_head = p_vld && (head_tag == p_tag);
  assign rule_now = pick_rule(buf_hit, pipe_matches_head, have_one, have_two,
                              head_tag == next_tag);

  always_comb begin
    iss_vld   = 1'b0;
    iss_a     = p_sum;
    iss_b     = head_data;
    iss_tag   = head_tag;
    pop_one   = 1'b0;
    pop_two   = 1'b0;
    take_buf  = 1'b0;
    pipe_used = 1'b0;
    merge_vld = 1'b0;
    merge_tag = head_tag;
    case (rule_now)
      RULE_BUF_PIPE: begin
        iss_vld = 1'b1; iss_b = buf_val; iss_tag = p_tag;
        take_buf = 1'b1; pipe_used = 1'b1;
        merge_vld = 1'b1; merge_tag = p_tag;
      end
      RULE_FIFO_PIPE: begin
        iss_vld = 1'b1; pop_one = 1'b1; pipe_used = 1'b1;
        merge_vld = 1'b1;
      end
      RULE_FIFO_PAIR: begin
        iss_vld = 1'b1; iss_a = head_data; iss_b = next_data;
        pop_two = 1'b1; merge_vld = 1'b1;
      end
      RULE_FIFO_ZERO: begin
        iss_vld = 1'b1; iss_a = head_data; iss_b = IDENT;
        pop_one = 1'b1;
      end
      default: ;
    endcase
  end

  rowred_fifo #(.DW(DATA_W), .TW(TAG_W), .DEPTH(FDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(in_vld), .push_data(in_data), .push_tag(in_tag),
    .pop_one(pop_one), .pop_two(pop_two),
    .head_data(head_data), .head_tag(head_tag),
    .next_data(next_data), .next_tag(next_tag),
    .level(level)
  );

  rowred_pipe #(.DW(DATA_W), .TW(TAG_W), .STAGES(STAGES)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_vld(iss_vld), .in_a(iss_a), .in_b(iss_b), .in_tag(iss_tag),
    .out_vld(p_vld), .out_sum(p_sum), .out_tag(p_tag)
  );

  rowred_store #(.DW(DATA_W), .TW(TAG_W), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .acc_vld(in_vld), .acc_tag(in_tag), .acc_last(in_last),
    .merge_vld(merge_vld), .merge_tag(merge_tag),
    .pv(p_vld), .ptag(p_tag), .psum(p_sum),
    .take_buf(take_buf), .pipe_used(pipe_used),
    .buf_hit(buf_hit), .buf_val(buf_val),
    .out_vld(out_vld), .out_sum(out_data), .out_tag(out_tag)
  );

  // R3: a matching parked partial always beats the queue
  p_buffer_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_hit |-> (pipe_used && !pop_one && !pop_two));

  // R7: with no adder output and under two queued values, the adder idles
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_vld && level < LW'(2)) |-> !iss_vld);

  // R6: the zero-partner case removes exactly one queued value
  p_zero_pops_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_now == RULE_FIFO_ZERO) |=>
      (level == $past(level) - LW'(1) + LW'($past(in_vld))));

  // R5: a same-tag pair removes exactly two queued values
  p_pair_pops_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_now == RULE_FIFO_PAIR) |=>
      (level == $past(level) - LW'(2) + LW'($past(in_vld))));

  // R4: queue head taken with adder output removes one queued value
  p_head_pipe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_now == RULE_FIFO_PIPE) |=>
      (level == $past(level) - LW'(1) + LW'($past(in_vld))));

endmodule

// File: tb/sim_rowred_top.sv
`timescale 1ns/1ps
module sim_rowred_top;

  localparam int DW = 16;
  localparam int TW = 4;
  localparam int FD = 32;
  localparam int ST = 6;
  localparam int NT = 1 << TW;
  localparam int NE = 32;
  localparam int NROW = 8;

  // entry: {valid, last, logical row, value}
  localparam logic [21:0] TBL [NE] = '{
    {1'b1,1'b1,4'd0,16'd5},
    {1'b1,1'b0,4'd1,16'd3},   {1'b1,1'b0,4'd1,16'd4},   {1'b1,1'b1,4'd1,16'd5},
    {1'b1,1'b0,4'd2,16'd1},   {1'b1,1'b0,4'd2,16'd2},   {1'b0,1'b0,4'd0,16'd0},
    {1'b1,1'b0,4'd2,16'd3},   {1'b1,1'b0,4'd2,16'd4},   {1'b1,1'b0,4'd2,16'd5},
    {1'b1,1'b0,4'd2,16'd6},   {1'b1,1'b1,4'd2,16'd7},
    {1'b1,1'b0,4'd3,16'hF000},{1'b1,1'b1,4'd3,16'h2000},
    {1'b1,1'b1,4'd4,16'd9},
    {1'b1,1'b0,4'd5,16'd100}, {1'b1,1'b0,4'd5,16'd101}, {1'b1,1'b0,4'd5,16'd102},
    {1'b1,1'b0,4'd5,16'd103}, {1'b1,1'b0,4'd5,16'd104}, {1'b1,1'b0,4'd5,16'd105},
    {1'b1,1'b0,4'd5,16'd106}, {1'b1,1'b0,4'd5,16'd107}, {1'b1,1'b0,4'd5,16'd108},
    {1'b1,1'b0,4'd5,16'd109}, {1'b1,1'b0,4'd5,16'd110}, {1'b1,1'b1,4'd5,16'd111},
    {1'b0,1'b0,4'd0,16'd0},
    {1'b1,1'b0,4'd6,16'h1000},{1'b1,1'b0,4'd6,16'd7},   {1'b1,1'b0,4'd6,16'd40},
    {1'b1,1'b1,4'd6,16'd300}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [TW-1:0] in_tag = '0;
  logic          in_last = 1'b0;
  logic          out_vld;
  logic [DW-1:0] out_data;
  logic [TW-1:0] out_tag;

  int total = 0;
  int bad = 0;
  int alloc_n [NT];
  int rel_n   [NT];
  int tag_of  [NROW];
  bit mapped  [NROW];
  logic [DW-1:0] exp_sum [NROW];
  int ord [NROW];
  int n_real = 0;
  int got = 0;
  bit table_mode = 1'b1;
  int dir_cnt = 0;
  logic [DW-1:0] dir_last = '0;
  logic [TW-1:0] dir_tag = '0;

  always #2.5 clk = ~clk;

  rowred_top #(.DATA_W(DW), .TAG_W(TW), .FDEPTH(FD), .STAGES(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .in_tag(in_tag), .in_last(in_last),
    .out_vld(out_vld), .out_data(out_data), .out_tag(out_tag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      rel_n[out_tag] = rel_n[out_tag] + 1;
      if (table_mode) begin
        if (got < n_real) begin
          // each sum exercises R3 R4 R5 R6 R8 via the scheduling mix
          check(out_data == exp_sum[ord[got]], "R9 row sum (R3 R4 R5 R6 R8)",
                int'(out_data), int'(exp_sum[ord[got]]));
          check(out_tag == TW'(tag_of[ord[got]]), "R10 arrival order tag",
                int'(out_tag), tag_of[ord[got]]);
          got++;
        end
      end else begin
        dir_cnt++;
        dir_last = out_data;
        dir_tag  = out_tag;
      end
    end
  end

  task automatic drive(input logic [DW-1:0] v, input int t, input logic l);
    @(posedge clk); #1;
    in_vld = 1'b1; in_data = v; in_tag = TW'(t); in_last = l;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_vld = 1'b0;
  endtask

  function automatic int free_tag();
    for (int t = 0; t < NT; t++)
      if (alloc_n[t] == rel_n[t]) return t;
    return -1;
  endfunction

  initial begin
    repeat (1000000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", got, n_real);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) begin alloc_n[t] = 0; rel_n[t] = 0; end
    for (int r = 0; r < NROW; r++) begin
      mapped[r] = 1'b0; exp_sum[r] = '0; tag_of[r] = 0;
    end
    // expected sums and first-arrival order, from the table
    for (int e = 0; e < NE; e++) begin
      if (TBL[e][21]) begin
        int r;
        bit seen_before;
        r = int'(TBL[e][19:16]);
        seen_before = 1'b0;
        for (int k = 0; k < n_real; k++) if (ord[k] == r) seen_before = 1'b1;
        if (!seen_before) begin ord[n_real] = r; n_real++; end
        exp_sum[r] = exp_sum[r] + TBL[e][15:0];
      end
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_vld == 1'b0, "R11 output idle in reset", int'(out_vld), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // table walk
    for (int e = 0; e < NE; e++) begin
      if (TBL[e][21]) begin
        int r;
        r = int'(TBL[e][19:16]);
        if (!mapped[r]) begin
          while (free_tag() < 0) idle();
          tag_of[r] = free_tag();
          alloc_n[tag_of[r]]++;
          mapped[r] = 1'b1;
        end
        drive(TBL[e][15:0], tag_of[r], TBL[e][20]);
      end else begin
        idle();
      end
    end
    // padding rows push lone trailing values out of the queue
    while (got < n_real) begin
      int t;
      t = free_tag();
      if (t >= 0) begin
        alloc_n[t]++;
        drive(16'd1, t, 1'b1);
      end else begin
        idle();
      end
    end
    idle();
    check(got == n_real, "R1 every accepted row summed", got, n_real);

    // reset in the middle of traffic
    table_mode = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(out_vld == 1'b0, "R11 output low under reset", int'(out_vld), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // latency of a fresh two-element row
    dir_cnt = 0;
    drive(16'h0010, 2, 1'b0);
    drive(16'h0023, 2, 1'b1);
    @(posedge clk); #1;
    in_vld = 1'b0;
    repeat (ST + 1) @(posedge clk);
    @(negedge clk);
    check(out_vld == 1'b0, "R2 no result one cycle early", int'(out_vld), 0);
    @(posedge clk);
    @(negedge clk);
    check(out_vld == 1'b1, "R2 result on time", int'(out_vld), 1);
    check(out_data == 16'h0033, "R11 sum free of pre-reset values",
          int'(out_data), 'h33);

    // lone queued value waits
    repeat (4) @(posedge clk);
    dir_cnt = 0;
    drive(16'd7, 5, 1'b1);
    idle();
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(dir_cnt == 0, "R7 lone value held in queue", dir_cnt, 0);

    // a second value releases it paired with zero
    drive(16'd9, 6, 1'b1);
    idle();
    repeat (ST + 10) @(posedge clk);
    @(negedge clk);
    check(dir_cnt == 1, "R6 head sent with zero partner", dir_cnt, 1);
    check(dir_last == 16'd7 && dir_tag == TW'(5), "R6 released sum and tag",
          int'(dir_last), 7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule